// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block owns the three phase-control lines a SCSI target drives (message, command/data and input/output) and decides when they may move and how long the rest of the target must wait before using the bus in the new phase. The sequencer takes a requested phase code, steps the lines to that phase as a single registered update, and raises a one-cycle `settled_o` strobe once the required settle time has passed. The data path waits for that strobe before it starts a transfer.

The sequencer waits while the initiator holds ACK, because the phase may not change during a handshake. A bus reset flag overrides that wait. The settle time has three parts: a base interval, an extra interval when the transfer direction flips, and a long extra interval for hosts that need legacy SCSI-1 timing. In legacy mode, entering a data phase also costs a long pre-wait before the lines move. The sequencer also sets synchronous transfer mode for data phases when a nonzero offset has been negotiated. Any phase code with bit 3 set means bus free: every output is released at once.

All intervals are parameters counted in clock cycles.

Top module: `scsi_phase_seq`

## Requirements
- R1: A request whose code equals the stored phase does nothing: `busy_o` stays low, no output changes and no `settled_o` strobe follows. All codes with bit 3 set count as one and the same bus-free phase.
- R2: While `ack_in` is high and `bus_rst` is low, an accepted change leaves the phase lines unchanged. The lines update on the first clock edge at which `ack_in` is sampled low.
- R3: With `bus_rst` high, a pending change goes ahead on the next edge even if `ack_in` is high.
- R4: For an information phase, `io_o` is code bit 0, `cd_o` is bit 1 and `msg_o` is bit 2. All three lines change on the same edge, and `ctl_oe_o` is high.
- R5: A bus-free code (bit 3 set) drives `msg_o`, `cd_o`, `io_o`, `ctl_oe_o`, `sync_en_o` and both sync parameter outputs low on the apply edge. `settled_o` pulses in the cycle right after that edge, so there is no settle delay, and the stored phase becomes bus free.
- R6: When the I/O bit does not change, `settled_o` pulses `SETTLE_CYC` edges after the apply edge.
- R7: When the new I/O bit differs from the `io_o` value before the change, `IO_FLIP_CYC` more edges are added.
- R8: With `legacy_mode` high at the apply edge, `LEGACY_SETTLE_CYC` more edges are added.
- R9: With `legacy_mode` high, a change into a data phase (bits 2 and 1 both zero) first waits `LEGACY_PRE_CYC` edges after ACK is released. Only then do the lines change.
- R10: `sync_en_o` is set on the apply edge only if the new phase is a data phase and `sync_offset_in` is nonzero. In that case `sync_offset_o` and `sync_period_o` take the input values; otherwise all three are zero.
- R11: `busy_o` is high from the accepting edge until the edge that raises `settled_o`. Requests seen while it is high are ignored, and `settled_o` never lasts more than one cycle.
- R12: After reset, all outputs are low and the stored phase is bus free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Phase request strobe |
| req_phase | input | 4 | Requested phase: bit 3 bus free, bit 2 MSG, bit 1 C/D, bit 0 I/O |
| ack_in | input | 1 | Initiator ACK, high = asserted |
| bus_rst | input | 1 | Bus reset flag; overrides the ACK wait |
| legacy_mode | input | 1 | SCSI-1 compatibility timing |
| sync_offset_in | input | SYNC_W | Negotiated synchronous offset |
| sync_period_in | input | SYNC_W | Negotiated synchronous period |
| msg_o | output | 1 | MSG line |
| cd_o | output | 1 | C/D line |
| io_o | output | 1 | I/O line |
| ctl_oe_o | output | 1 | Control output enable |
| sync_en_o | output | 1 | Synchronous transfer mode |
| sync_offset_o | output | SYNC_W | Offset for the data path |
| sync_period_o | output | SYNC_W | Period for the data path |
| settled_o | output | 1 | One-cycle strobe when the settle time has passed |
| busy_o | output | 1 | A change is pending or settling |

## Verification
The assertions assume that `req_valid` is a clean synchronous strobe and that `ack_in` and `bus_rst` are already synchronised to `clk`. They also assume that the bus-free state is recognised by a low `ctl_oe_o`, which makes the stored phase visible at the ports. The stimulus changes every input on the falling edge and raises `ack_in` only around a request, never during a pre-wait. It holds `legacy_mode` and the sync inputs steady for the whole of each change, so the value sampled at the apply edge is the one the reference model uses.

// File: rtl/scsi_seq_pkg.sv
// Package: shared phase type, sequencer states and phase helpers.
// Assumes: the phase code is 4 bits, and bit 3 marks bus free.
package scsi_seq_pkg;

    typedef struct packed {
        logic rel;   // bus free / released
        logic msg;
        logic cd;
        logic io;
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_PRE    = 2'd2,
        ST_SETTLE = 2'd3
    } seq_state_t;

    localparam phase_t PH_FREE = '{rel: 1'b1, msg: 1'b0, cd: 1'b0, io: 1'b0};

    // True for data-in and data-out.
    function automatic logic is_data(input phase_t p);
        return !p.rel && !p.msg && !p.cd;
    endfunction

    // Phase equality; every bus-free code counts as the same phase.
    function automatic logic same_phase(input phase_t a, input phase_t b);
        return (a.rel && b.rel) || (a == b);
    endfunction

endpackage

// File: rtl/scsi_seq_timer.sv
// Module: loadable down counter that stops at zero.
// Assumes: a load takes priority over counting down; zero_o is the state
// of the register, not of the value being loaded.
module scsi_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    // Count down toward zero, or reload when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/scsi_seq_delay.sv
// Module: works out, without state, the reload values (interval minus one)
// for the settle time and the legacy pre-wait.
// Assumes: SETTLE_CYC >= 1 and LEGACY_PRE_CYC >= 1; W holds the largest sum.
module scsi_seq_delay #(
    parameter int W                 = 16,
    parameter int SETTLE_CYC        = 50,
    parameter int IO_FLIP_CYC       = 50,
    parameter int LEGACY_SETTLE_CYC = 12500,
    parameter int LEGACY_PRE_CYC    = 50000
) (
    input  logic         new_io,
    input  logic         old_io,
    input  logic         legacy,
    output logic [W-1:0] settle_m1,
    output logic [W-1:0] pre_m1
);
    localparam logic [W-1:0] BASE_M1 = W'(SETTLE_CYC - 1);
    localparam logic [W-1:0] FLIP    = W'(IO_FLIP_CYC);
    localparam logic [W-1:0] LEG     = W'(LEGACY_SETTLE_CYC);

    logic [W-1:0] flip_term;
    logic [W-1:0] leg_term;

    // Direction-flip term; left out entirely when the parameter is zero.
    generate
        if (IO_FLIP_CYC > 0) begin : g_flip
            assign flip_term = (new_io != old_io) ? FLIP : '0;
        end else begin : g_noflip
            assign flip_term = '0;
        end
    endgenerate

    // Legacy settle term; left out entirely when the parameter is zero.
    generate
        if (LEGACY_SETTLE_CYC > 0) begin : g_leg
            assign leg_term = legacy ? LEG : '0;
        end else begin : g_noleg
            assign leg_term = '0;
        end
    endgenerate

    assign settle_m1 = BASE_M1 + flip_term + leg_term;
    assign pre_m1    = W'(LEGACY_PRE_CYC - 1);
endmodule

// File: rtl/scsi_phase_seq.sv
// Module: SCSI target phase sequencer (top).
// Accepts a phase request, waits for ACK to be released (or for a bus reset),
// optionally runs the legacy data-phase pre-wait, then updates MSG, C/D and I/O
// on one edge and times the settle interval before strobing settled_o.
// Assumes: inputs are synchronous to clk; all intervals are counted in clk cycles.
module scsi_phase_seq #(
    parameter int SYNC_W            = 8,
    parameter int SETTLE_CYC        = 50,
    parameter int IO_FLIP_CYC       = 50,
    parameter int LEGACY_SETTLE_CYC = 12500,
    parameter int LEGACY_PRE_CYC    = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_phase,
    input  logic              ack_in,
    input  logic              bus_rst,
    input  logic              legacy_mode,
    input  logic [SYNC_W-1:0] sync_offset_in,
    input  logic [SYNC_W-1:0] sync_period_in,
    output logic              msg_o,
    output logic              cd_o,
    output logic              io_o,
    output logic              ctl_oe_o,
    output logic              sync_en_o,
    output logic [SYNC_W-1:0] sync_offset_o,
    output logic [SYNC_W-1:0] sync_period_o,
    output logic              settled_o,
    output logic              busy_o
);
    import scsi_seq_pkg::*;

    localparam int SETTLE_MAX = SETTLE_CYC + IO_FLIP_CYC + LEGACY_SETTLE_CYC;
    localparam int MAX_CNT    = (SETTLE_MAX > LEGACY_PRE_CYC) ? SETTLE_MAX : LEGACY_PRE_CYC;
    localparam int CW         = $clog2(MAX_CNT + 1);

    seq_state_t  state;
    phase_t      cur_ph;
    phase_t      tgt_ph;
    phase_t      req_ph;
    logic        go;
    logic        need_pre;
    logic        apply_now;
    logic        enter_pre;
    logic        tmr_load;
    logic        tmr_zero;
    logic [CW-1:0] settle_m1;
    logic [CW-1:0] pre_m1;
    logic [CW-1:0] tmr_val;
    logic        want_sync;

    assign req_ph = phase_t'(req_phase);

    // Work out when a pending change may go ahead and which path it takes.
    always_comb begin
        go        = !ack_in || bus_rst;
        need_pre  = legacy_mode && is_data(tgt_ph);
        enter_pre = (state == ST_HOLD) && go && !tgt_ph.rel && need_pre;
        apply_now = ((state == ST_HOLD) && go && !tgt_ph.rel && !need_pre) ||
                    ((state == ST_PRE) && tmr_zero && go);
        tmr_load  = enter_pre || apply_now;
        tmr_val   = enter_pre ? pre_m1 : settle_m1;
        want_sync = is_data(tgt_ph) && (sync_offset_in != '0);
    end

    scsi_seq_delay #(
        .W                 (CW),
        .SETTLE_CYC        (SETTLE_CYC),
        .IO_FLIP_CYC       (IO_FLIP_CYC),
        .LEGACY_SETTLE_CYC (LEGACY_SETTLE_CYC),
        .LEGACY_PRE_CYC    (LEGACY_PRE_CYC)
    ) u_delay (
        .new_io    (tgt_ph.io),
        .old_io    (io_o),
        .legacy    (legacy_mode),
        .settle_m1 (settle_m1),
        .pre_m1    (pre_m1)
    );

    scsi_seq_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero_o   (tmr_zero)
    );

    // Sequencer state, stored phase, registered lines and the settle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cur_ph        <= PH_FREE;
            tgt_ph        <= PH_FREE;
            msg_o         <= 1'b0;
            cd_o          <= 1'b0;
            io_o          <= 1'b0;
            ctl_oe_o      <= 1'b0;
            sync_en_o     <= 1'b0;
            sync_offset_o <= '0;
            sync_period_o <= '0;
            settled_o     <= 1'b0;
        end else begin
            settled_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && !same_phase(req_ph, cur_ph)) begin
                        tgt_ph <= req_ph;
                        state  <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (go && tgt_ph.rel) begin
                        msg_o         <= 1'b0;
                        cd_o          <= 1'b0;
                        io_o          <= 1'b0;
                        ctl_oe_o      <= 1'b0;
                        sync_en_o     <= 1'b0;
                        sync_offset_o <= '0;
                        sync_period_o <= '0;
                        cur_ph        <= PH_FREE;
                        settled_o     <= 1'b1;
                        state         <= ST_IDLE;
                    end else if (enter_pre) begin
                        state <= ST_PRE;
                    end else if (apply_now) begin
                        state <= ST_SETTLE;
                    end
                end
                ST_PRE: begin
                    if (apply_now) state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        settled_o <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase

            if (apply_now) begin
                msg_o         <= tgt_ph.msg;
                cd_o          <= tgt_ph.cd;
                io_o          <= tgt_ph.io;
                ctl_oe_o      <= 1'b1;
                cur_ph        <= tgt_ph;
                sync_en_o     <= want_sync;
                sync_offset_o <= want_sync ? sync_offset_in : '0;
                sync_period_o <= want_sync ? sync_period_in : '0;
            end
        end
    end

    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/scsi_phase_seq_chk.sv
// Module: assertion checker for scsi_phase_seq, attached with bind.
// Assumes: the bus-free stored phase shows up as ctl_oe_o low.
module scsi_phase_seq_chk #(
    parameter int SYNC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_phase,
    input logic              ack_in,
    input logic              bus_rst,
    input logic              msg_o,
    input logic              cd_o,
    input logic              io_o,
    input logic              ctl_oe_o,
    input logic              sync_en_o,
    input logic [SYNC_W-1:0] sync_offset_o,
    input logic [SYNC_W-1:0] sync_period_o,
    input logic              settled_o,
    input logic              busy_o
);
    logic req_same;

    // Request matches the phase visible at the ports.
    always_comb begin
        req_same = (req_phase[3] && !ctl_oe_o) ||
                   (!req_phase[3] && ctl_oe_o && (req_phase[2:0] == {msg_o, cd_o, io_o}));
    end

    p_same_noop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid && req_same) |=> !busy_o);

    p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !bus_rst) |=> $stable({msg_o, cd_o, io_o, ctl_oe_o}));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe_o |-> (!msg_o && !cd_o && !io_o && !sync_en_o &&
                       sync_offset_o == '0 && sync_period_o == '0));

    p_sync_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en_o |-> (ctl_oe_o && !msg_o && !cd_o && sync_offset_o != '0));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |=> !settled_o);

    p_idle_on_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |-> !busy_o);
endmodule

bind scsi_phase_seq scsi_phase_seq_chk #(.SYNC_W(SYNC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_phase     (req_phase),
    .ack_in        (ack_in),
    .bus_rst       (bus_rst),
    .msg_o         (msg_o),
    .cd_o          (cd_o),
    .io_o          (io_o),
    .ctl_oe_o      (ctl_oe_o),
    .sync_en_o     (sync_en_o),
    .sync_offset_o (sync_offset_o),
    .sync_period_o (sync_period_o),
    .settled_o     (settled_o),
    .busy_o        (busy_o)
);

// File: tb/sim_scsi_phase_seq.sv
// Bench: a behavioural reference model compared every clock, plus directed
// latency checks. Inputs change on the falling edge; outputs are sampled there too.
module sim_scsi_phase_seq;
    localparam int SW   = 8;
    localparam int SET  = 50;
    localparam int FLIP = 50;
    localparam int LEG  = 300;
    localparam int PRE  = 700;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_phase = 4'h8;
    logic          ack_in = 1'b0;
    logic          bus_rst = 1'b0;
    logic          legacy_mode = 1'b0;
    logic [SW-1:0] sync_offset_in = '0;
    logic [SW-1:0] sync_period_in = '0;
    logic          msg_o, cd_o, io_o, ctl_oe_o, sync_en_o, settled_o, busy_o;
    logic [SW-1:0] sync_offset_o, sync_period_o;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    scsi_phase_seq #(
        .SYNC_W(SW), .SETTLE_CYC(SET), .IO_FLIP_CYC(FLIP),
        .LEGACY_SETTLE_CYC(LEG), .LEGACY_PRE_CYC(PRE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phase(req_phase),
        .ack_in(ack_in), .bus_rst(bus_rst), .legacy_mode(legacy_mode),
        .sync_offset_in(sync_offset_in), .sync_period_in(sync_period_in),
        .msg_o(msg_o), .cd_o(cd_o), .io_o(io_o), .ctl_oe_o(ctl_oe_o),
        .sync_en_o(sync_en_o), .sync_offset_o(sync_offset_o),
        .sync_period_o(sync_period_o), .settled_o(settled_o), .busy_o(busy_o)
    );

    // Reference model: a waiting stage and a remaining-cycle count.
    int        m_stage;     // 0 idle, 1 ack wait, 2 pre-wait, 3 settling
    int        m_left;
    logic [3:0] m_tgt, m_cur;
    logic       m_msg, m_cd, m_io, m_oe, m_sen, m_set;
    logic [SW-1:0] m_off, m_per;

    function automatic bit m_same(input logic [3:0] a, input logic [3:0] b);
        return (a[3] && b[3]) || (a == b);
    endfunction

    task automatic m_apply();
        int d;
        bit sy;
        d = SET + ((m_tgt[0] != m_io) ? FLIP : 0) + (legacy_mode ? LEG : 0);
        sy = (m_tgt[2:1] == 2'b00) && (sync_offset_in != 0);
        m_msg = m_tgt[2]; m_cd = m_tgt[1]; m_io = m_tgt[0]; m_oe = 1'b1;
        m_sen = sy; m_off = sy ? sync_offset_in : '0; m_per = sy ? sync_period_in : '0;
        m_cur = m_tgt; m_left = d - 1; m_stage = 3;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_left = 0; m_tgt = 4'h8; m_cur = 4'h8;
            {m_msg, m_cd, m_io, m_oe, m_sen, m_set} = '0; m_off = '0; m_per = '0;
        end else begin
            m_set = 1'b0;
            case (m_stage)
                0: if (req_valid && !m_same(req_phase, m_cur)) begin
                       m_tgt = req_phase; m_stage = 1;
                   end
                1: if (!ack_in || bus_rst) begin
                       if (m_tgt[3]) begin
                           {m_msg, m_cd, m_io, m_oe, m_sen} = '0; m_off = '0; m_per = '0;
                           m_cur = 4'h8; m_set = 1'b1; m_stage = 0;
                       end else if (legacy_mode && m_tgt[2:1] == 2'b00) begin
                           m_left = PRE - 1; m_stage = 2;
                       end else m_apply();
                   end
                2: if (m_left == 0) begin
                       if (!ack_in || bus_rst) m_apply();
                   end else m_left = m_left - 1;
                default: if (m_left == 0) begin
                       m_set = 1'b1; m_stage = 0;
                   end else m_left = m_left - 1;
            endcase
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4 lines", {msg_o, cd_o, io_o}, {m_msg, m_cd, m_io});
            chk("R5 oe", ctl_oe_o, m_oe);
            chk("R10 sync", {sync_en_o, sync_offset_o, sync_period_o}, {m_sen, m_off, m_per});
            chk("R6 settled", settled_o, m_set);
            chk("R11 busy", busy_o, m_stage != 0);
        end
    end

    // Drive one request and count falling edges until settled_o is seen.
    task automatic request(input logic [3:0] ph, output int lat);
        req_phase = ph; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        lat = 1;
        while (!settled_o && lat < 3000) begin
            @(negedge clk); lat++;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        chk("R12 reset lines", {msg_o, cd_o, io_o, ctl_oe_o, sync_en_o, settled_o, busy_o}, 0);

        // R1: bus free requested while already free.
        req_phase = 4'hC; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        chk("R1 no busy", busy_o, 0);
        repeat (3) @(negedge clk);
        chk("R1 no strobe", settled_o, 0);

        // R6: command phase, I/O unchanged.
        request(4'b0010, lat); chk("R6 latency", lat, SET + 2);
        @(negedge clk); chk("R11 single pulse", settled_o, 0);
        // R7: status phase flips I/O.
        request(4'b0011, lat); chk("R7 latency", lat, SET + FLIP + 2);
        chk("R4 status lines", {ctl_oe_o, msg_o, cd_o, io_o}, 4'b1011);
        // R1: same phase again.
        req_phase = 4'b0011; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        chk("R1 same phase", busy_o, 0);

        // R11: a request while busy is ignored.
        req_phase = 4'b0000; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        repeat (10) @(negedge clk);
        req_phase = 4'b0111; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        while (!settled_o) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R11 ignored", {msg_o, cd_o, io_o}, 3'b000);
        chk("R11 still idle", busy_o, 0);

        // R2 and R10: ACK held, data-in with a synchronous offset.
        sync_offset_in = 8'd5; sync_period_in = 8'd12; ack_in = 1'b1;
        req_phase = 4'b0001; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 held", {msg_o, cd_o, io_o}, 3'b000);
        chk("R2 busy", busy_o, 1);
        ack_in = 1'b0; @(negedge clk);
        chk("R2 released", {msg_o, cd_o, io_o}, 3'b001);
        chk("R10 sync on", {sync_en_o, sync_offset_o, sync_period_o}, {1'b1, 8'd5, 8'd12});
        while (!settled_o) @(negedge clk);

        // R3: bus reset overrides the ACK hold; R10 off in a message phase.
        ack_in = 1'b1; bus_rst = 1'b1;
        req_phase = 4'b0110; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk("R3 override", {msg_o, cd_o, io_o}, 3'b110);
        chk("R10 sync off", sync_en_o, 0);
        ack_in = 1'b0; bus_rst = 1'b0;
        while (!settled_o) @(negedge clk);

        // R10: data-out with zero offset stays asynchronous.
        sync_offset_in = 8'd0;
        request(4'b0000, lat);
        chk("R10 zero offset", sync_en_o, 0);

        // R8: legacy settle added (command, I/O unchanged).
        legacy_mode = 1'b1;
        request(4'b0010, lat); chk("R8 latency", lat, SET + LEG + 2);
        // R9: legacy data-in pre-wait, lines unchanged mid-wait.
        req_phase = 4'b0001; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
        repeat (300) @(negedge clk);
        chk("R9 pre-wait lines", {msg_o, cd_o, io_o}, 3'b010);
        lat = 301;
        while (!settled_o && lat < 3000) begin @(negedge clk); lat++; end
        chk("R9 latency", lat, PRE + SET + FLIP + LEG + 2);
        legacy_mode = 1'b0;

        // R5: release to bus free, zero delay.
        sync_offset_in = 8'd3;
        request(4'b1000, lat); chk("R5 latency", lat, 2);
        chk("R5 released", {msg_o, cd_o, io_o, ctl_oe_o, sync_en_o}, 0);
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule